// File: doc/BRIEF.md
# Register-Programmed Short-Transfer I2C Master

This block is an I2C bus master for short transactions of one to eight bytes, driven entirely through a small set of word registers. Software places the 8-bit address byte in the address register. The 7-bit device address sits in bits 7:1 and bit 0 is the direction bit. Software stages up to eight data bytes in two 32-bit data words. It writes the byte count and the direction into the configuration register. None of these settings reach the engine directly. They sit in shadow copies until a self-clearing load strobe moves them into the active set. A later write of the go bit starts the transfer.

The engine produces a start condition, the address byte, and the data bytes, checking the acknowledge after every byte it sends. On reads it acknowledges every received byte except the final one. It ends with a stop condition. SCL and SDA are open-drain: the block only ever pulls a line low or releases it, and it reads the real bus level back. SCL timing comes from a divisor, and the engine waits for SCL to actually rise before it continues. Busy and no-acknowledge results are reported in a status register. Received bytes land in the same two data words, in the same byte layout used for writes.

Top module: `i2c_rm_master`

## Requirements
- R1: After reset, every register reads zero, busy is low and neither bus line is pulled low.
- R2: Writes to the configuration, address and divisor registers (word offsets 0, 1, 5) change only shadow copies. Reading those offsets returns the active values, and these change only through the load strobe.
- R3: Writing 1 to bit 0 of the load register (offset 6) sets that bit. When the block is idle, the shadow copy moves to the active set on the next clock edge and the bit reads 0 from then on. If a transfer is running, the bit stays set until the transfer ends and the copy happens one cycle after busy falls.
- R4: Writing configuration bit 9 while idle starts a transfer. Bit 9 reads 1 while the transfer runs and 0 after it ends. Writing bit 10 (the other-mode start) has no effect: busy stays low and no start condition appears.
- R5: A transfer sends the active address register byte, MSB first, right after the start condition. It moves (active configuration bits 3:1) + 1 data bytes, and configuration bit 6 set means read.
- R6: On a write, data byte k is taken from data word 0 (offset 2) for k < 4 and from data word 1 (offset 3) otherwise, at bits 8*(k mod 4)+7 : 8*(k mod 4). Bytes are sent in ascending k, each MSB first.
- R7: On a read, received byte k is stored in the same lane that R6 defines. Lanes at or above the byte count are left unchanged.
- R8: On a read, the master drives an acknowledge (SDA low) after every byte except the last. It leaves SDA high after the last byte and then issues a stop.
- R9: If the address byte is not acknowledged, status bit 0 is set, no data byte is clocked, and a stop follows at once.
- R10: If a write data byte is not acknowledged, status bit 1 is set and the transfer stops after that byte. The remaining bytes are never sent.
- R11: Status bit 8 is busy, from the go write until the stop condition completes. Status bits 3:0 hold the no-acknowledge flags of the last transfer and clear at the next go. While idle, both lines are released.
- R12: One SCL bit period lasts 4*(D+1) clock cycles when SCL is not held low by another device. D is bits 31:16 of the active divisor register (offset 5). Bits 15:0 of that register are stored and read back but do not affect timing.
- R13: Within a byte, SDA changes only while SCL is low. SDA moves with SCL high only to form the start and stop conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Word offset of the register written |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Word offset of the register read |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| scl_i | input | 1 | Sensed SCL bus level |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_i | input | 1 | Sensed SDA bus level |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The bench runs an open-drain target model on the shared bus. It aims at byte-lane ordering: single-byte, full eight-byte and five-byte writes catch a design that swaps data words or sends bytes LSB first. Reads of eight bytes and of three bytes catch a design that clobbers lanes past the count or acknowledges the final byte, which would leave the target driving SDA through the stop. A wrong device address and a target that refuses the third data byte check that the engine stops at once with the right status bit, and does not clock further bytes. A design that ignored the shadow scheme would show new values before the load. One that copied while busy would change the load read-back in mid-transfer. A design that did not scale the divisor's upper half would show the wrong SCL period.

// File: rtl/i2c_rm_pkg.sv
`timescale 1ns/1ps
package i2c_rm_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_CFG  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_ADDR = 3'd1;
  localparam logic [REG_AW-1:0] OFF_DLO  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_DHI  = 3'd3;
  localparam logic [REG_AW-1:0] OFF_STAT = 3'd4;
  localparam logic [REG_AW-1:0] OFF_DIV  = 3'd5;
  localparam logic [REG_AW-1:0] OFF_LOAD = 3'd6;

  localparam int CFG_GO_BIT  = 9;
  localparam int CFG_RD_BIT  = 6;
  localparam int CFG_CNT_LSB = 1;
  localparam int CNT_W       = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} eng_state_t;

  // Number of data bytes from the stored count-minus-one field.
  function automatic logic [3:0] xfer_len(input logic [CNT_W-1:0] cnt_m1);
    return {1'b0, cnt_m1} + 4'd1;
  endfunction

  // Byte k of the eight-byte staging area (low word holds bytes 0..3).
  function automatic logic [7:0] lane_pick(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [2:0] idx);
    logic [31:0] w;
    w = idx[2] ? hi : lo;
    return w[{idx[1:0], 3'b000} +: 8];
  endfunction

  // Replace one byte lane of a data word.
  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/i2c_rm_tick.sv
`timescale 1ns/1ps
module i2c_rm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_rm_regs.sv
`timescale 1ns/1ps
module i2c_rm_regs
  import i2c_rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [REG_AW-1:0] raddr,
  output logic [REG_DW-1:0] rdata,
  input  logic              busy,
  input  logic              nack_addr,
  input  logic              nack_data,
  input  logic              rx_we,
  input  logic [2:0]        rx_idx,
  input  logic [7:0]        rx_byte,
  output logic              go,
  output logic [7:0]        ac_addr,
  output logic [CNT_W-1:0]  ac_cnt,
  output logic              ac_rd,
  output logic [REG_DW-1:0] ac_div,
  output logic [REG_DW-1:0] data_lo,
  output logic [REG_DW-1:0] data_hi,
  output logic              load_pend,
  output logic              load_copy,
  output logic              load_wr
);
  logic [7:0]        sh_addr;
  logic [CNT_W-1:0]  sh_cnt;
  logic              sh_rd;
  logic [REG_DW-1:0] sh_div;

  logic wr_cfg, wr_addr, wr_lo, wr_hi, wr_div, wr_load;
  assign wr_cfg  = we && (waddr == OFF_CFG);
  assign wr_addr = we && (waddr == OFF_ADDR);
  assign wr_lo   = we && (waddr == OFF_DLO);
  assign wr_hi   = we && (waddr == OFF_DHI);
  assign wr_div  = we && (waddr == OFF_DIV);
  assign wr_load = we && (waddr == OFF_LOAD);

  assign go        = wr_cfg && wdata[CFG_GO_BIT] && !busy;
  assign load_wr   = wr_load && wdata[0];
  assign load_copy = load_pend && !busy && !go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_addr <= '0; sh_cnt <= '0; sh_rd <= 1'b0; sh_div <= '0;
      ac_addr <= '0; ac_cnt <= '0; ac_rd <= 1'b0; ac_div <= '0;
      load_pend <= 1'b0;
    end else begin
      if (wr_cfg) begin
        sh_cnt <= wdata[CFG_CNT_LSB +: CNT_W];
        sh_rd  <= wdata[CFG_RD_BIT];
      end
      if (wr_addr) sh_addr <= wdata[7:0];
      if (wr_div)  sh_div  <= wdata;
      if (load_copy) begin
        ac_addr <= sh_addr; ac_cnt <= sh_cnt; ac_rd <= sh_rd; ac_div <= sh_div;
      end
      if (load_wr)        load_pend <= 1'b1;
      else if (load_copy) load_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_lo <= '0;
      data_hi <= '0;
    end else begin
      if (wr_lo)                    data_lo <= wdata;
      else if (rx_we && !rx_idx[2]) data_lo <= lane_put(data_lo, rx_idx[1:0], rx_byte);
      if (wr_hi)                    data_hi <= wdata;
      else if (rx_we && rx_idx[2])  data_hi <= lane_put(data_hi, rx_idx[1:0], rx_byte);
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      OFF_CFG: begin
        rdata[CFG_GO_BIT]               = busy;
        rdata[CFG_RD_BIT]               = ac_rd;
        rdata[CFG_CNT_LSB +: CNT_W]     = ac_cnt;
      end
      OFF_ADDR: rdata[7:0] = ac_addr;
      OFF_DLO:  rdata = data_lo;
      OFF_DHI:  rdata = data_hi;
      OFF_STAT: begin
        rdata[8] = busy;
        rdata[1] = nack_data;
        rdata[0] = nack_addr;
      end
      OFF_DIV:  rdata = ac_div;
      OFF_LOAD: rdata[0] = load_pend;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_rm_engine.sv
`timescale 1ns/1ps
module i2c_rm_engine
  import i2c_rm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic [7:0]       addr_byte,
  input  logic [CNT_W-1:0] cnt_m1,
  input  logic             rd_mode,
  input  logic [31:0]      data_lo,
  input  logic [31:0]      data_hi,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             busy,
  output logic             nack_addr,
  output logic             nack_data,
  output logic             scl_low,
  output logic             sda_low,
  output logic             rx_we,
  output logic [2:0]       rx_idx,
  output logic [7:0]       rx_byte,
  output logic             in_start,
  output logic             in_stop
);
  eng_state_t state;
  logic [1:0] ph;
  logic [3:0] bit_i;
  logic [3:0] byte_i;
  logic [7:0] tx_sh;
  logic [7:0] rx_sh;
  logic       ack_hi;

  logic       ack_slot, last_byte, rx_phase;
  logic [3:0] byte_m1;
  assign ack_slot  = (bit_i == 4'd8);
  assign last_byte = (byte_i == xfer_len(cnt_m1));
  assign rx_phase  = (byte_i != 4'd0) && rd_mode;
  assign byte_m1   = byte_i - 4'd1;

  assign busy     = (state != ST_IDLE);
  assign in_start = (state == ST_START);
  assign in_stop  = (state == ST_STOP);
  assign rx_we    = tick && (state == ST_BIT) && (ph == 2'd3) && ack_slot && rx_phase;
  assign rx_idx   = byte_m1[2:0];
  assign rx_byte  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; ph <= 2'd0; bit_i <= '0; byte_i <= '0;
      tx_sh <= '0; rx_sh <= '0; ack_hi <= 1'b0;
      nack_addr <= 1'b0; nack_data <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_START; ph <= 2'd0; bit_i <= '0; byte_i <= '0;
          tx_sh <= addr_byte; nack_addr <= 1'b0; nack_data <= 1'b0;
        end
        ST_START: if (tick) begin
          case (ph)
            2'd0: ph <= 2'd1;
            2'd1: ph <= 2'd2;
            2'd2: if (scl_i) begin sda_low <= 1'b1; ph <= 2'd3; end
            default: begin scl_low <= 1'b1; state <= ST_BIT; ph <= 2'd0; end
          endcase
        end
        ST_BIT: if (tick) begin
          case (ph)
            2'd0: begin
              if (!ack_slot) sda_low <= rx_phase ? 1'b0 : !tx_sh[7];
              else           sda_low <= rx_phase && !last_byte;
              ph <= 2'd1;
            end
            2'd1: begin scl_low <= 1'b0; ph <= 2'd2; end
            2'd2: if (scl_i) begin
              if (!ack_slot) rx_sh <= {rx_sh[6:0], sda_i};
              else           ack_hi <= sda_i;
              ph <= 2'd3;
            end
            default: begin
              scl_low <= 1'b1;
              ph <= 2'd0;
              if (!ack_slot) begin
                bit_i <= bit_i + 4'd1;
                tx_sh <= {tx_sh[6:0], 1'b0};
              end else if (!rx_phase && ack_hi) begin
                if (byte_i == 4'd0) nack_addr <= 1'b1;
                else                nack_data <= 1'b1;
                state <= ST_STOP;
              end else if (last_byte) begin
                state <= ST_STOP;
              end else begin
                byte_i <= byte_i + 4'd1;
                bit_i  <= '0;
                tx_sh  <= lane_pick(data_lo, data_hi, byte_i[2:0]);
              end
            end
          endcase
        end
        default: if (tick) begin
          case (ph)
            2'd0: begin sda_low <= 1'b1; ph <= 2'd1; end
            2'd1: begin scl_low <= 1'b0; ph <= 2'd2; end
            2'd2: if (scl_i) ph <= 2'd3;
            default: begin sda_low <= 1'b0; state <= ST_IDLE; ph <= 2'd0; end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_rm_master.sv
`timescale 1ns/1ps
module i2c_rm_master
  import i2c_rm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              scl_i,
  output logic              scl_drive_low,
  input  logic              sda_i,
  output logic              sda_drive_low
);
  localparam int DIV_LSB = REG_DW - DIV_W;

  logic              go_pulse, eng_busy, nack_addr, nack_data;
  logic              rx_we, tick, in_start, in_stop;
  logic [2:0]        rx_idx;
  logic [7:0]        rx_byte, ac_addr;
  logic [CNT_W-1:0]  ac_cnt;
  logic              ac_rd, load_pend, load_copy, load_wr;
  logic [REG_DW-1:0] ac_div, data_lo, data_hi;

  i2c_rm_regs regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .busy(eng_busy), .nack_addr(nack_addr),
    .nack_data(nack_data), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .go(go_pulse), .ac_addr(ac_addr), .ac_cnt(ac_cnt), .ac_rd(ac_rd), .ac_div(ac_div),
    .data_lo(data_lo), .data_hi(data_hi), .load_pend(load_pend),
    .load_copy(load_copy), .load_wr(load_wr)
  );

  i2c_rm_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .div(ac_div[DIV_LSB +: DIV_W]), .tick(tick)
  );

  i2c_rm_engine eng_i (
    .clk(clk), .rst_n(rst_n), .go(go_pulse), .tick(tick), .addr_byte(ac_addr),
    .cnt_m1(ac_cnt), .rd_mode(ac_rd), .data_lo(data_lo), .data_hi(data_hi),
    .scl_i(scl_i), .sda_i(sda_i), .busy(eng_busy), .nack_addr(nack_addr),
    .nack_data(nack_data), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .in_start(in_start), .in_stop(in_stop)
  );
endmodule

// File: rtl/i2c_rm_checker.sv
`timescale 1ns/1ps
module i2c_rm_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic go,
  input logic scl_low,
  input logic sda_low,
  input logic in_start,
  input logic in_stop,
  input logic nack_addr,
  input logic load_copy,
  input logic load_wr,
  input logic load_pend
);
  // R11: a start request makes the engine busy on the next cycle
  a_r11_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R11: an idle engine leaves both lines released
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  // R13: with SCL released on both sides, SDA may move only for start or stop
  a_r13_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && !$stable(sda_low)) |-> $past(in_start || in_stop));

  // R9: an address refusal lands the engine directly in the stop sequence
  a_r9_addr_nack_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_addr) |-> in_stop);

  // R3: a completed copy clears the pending load unless a new one arrived
  a_r3_load_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load_copy && !load_wr) |=> !load_pend);

  // R3: no copy happens while a transfer is running
  a_r3_no_copy_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_copy);
endmodule

bind i2c_rm_master i2c_rm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .go(go_pulse),
  .scl_low(scl_drive_low), .sda_low(sda_drive_low), .in_start(in_start),
  .in_stop(in_stop), .nack_addr(nack_addr), .load_copy(load_copy),
  .load_wr(load_wr), .load_pend(load_pend)
);

// File: tb/i2c_rm_master_tb_top.sv
`timescale 1ns/1ps
module i2c_rm_master_tb_top;
  localparam logic [2:0] A_CFG = 3'd0, A_ADDR = 3'd1, A_LO = 3'd2, A_HI = 3'd3,
                         A_STAT = 3'd4, A_DIV = 3'd5, A_LOAD = 3'd6;
  localparam logic [6:0] TGT = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic m_scl_low, m_sda_low;
  logic s_sda_low = 1'b0;
  wire scl_bus = !m_scl_low;
  wire sda_bus = !(m_sda_low || s_sda_low);

  always #2.5 clk = ~clk;

  i2c_rm_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .scl_i(scl_bus), .scl_drive_low(m_scl_low), .sda_i(sda_bus), .sda_drive_low(m_sda_low)
  );

  int checks = 0, errors = 0;
  int cyc = 0, last_rise = 0, last_period = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge scl_bus) begin
    last_period = cyc - last_rise;
    last_rise = cyc;
  end

  // ---------------- target model with scoreboard monitor ----------------
  logic [7:0] exp_q[$];
  bit mack_q[$];
  int start_cnt = 0, stop_cnt = 0, got_cnt = 0, nack_at = 0;
  int bc = 0, bn = 0;
  bit s_act = 0, s_rd = 0, s_match = 0, s_cont = 0;
  logic [7:0] s_sh = '0, s_tx = '0, popped;

  function automatic logic [7:0] rmem(input int i);
    return 8'hA1 + 8'(i * 29);
  endfunction

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin
    s_act = 1; bc = 0; bn = 0; s_sda_low = 0; start_cnt++;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1 && s_act) begin
    s_act = 0; s_sda_low = 0; stop_cnt++;
  end
  always @(posedge scl_bus) if (s_act) begin
    bc++;
    if (bc <= 8 && (bn == 0 || !s_rd)) s_sh = {s_sh[6:0], sda_bus};
    if (bc == 9 && s_rd && bn > 0) mack_q.push_back(sda_bus);
  end
  always @(negedge scl_bus) if (s_act) begin
    if (bc >= 1 && bc <= 7 && s_rd && bn > 0) s_sda_low = !s_tx[7-bc];
    else if (bc == 8) begin
      if (bn == 0) begin
        s_match = (s_sh[7:1] == TGT); s_rd = s_sh[0]; s_sda_low = s_match;
      end else if (!s_rd) begin
        got_cnt++;
        if (exp_q.size() == 0) chk(0, "R6", "unexpected write byte", s_sh, 0);
        else begin
          popped = exp_q.pop_front();
          chk(s_sh == popped, "R6", "write byte order", s_sh, popped);
        end
        s_sda_low = (bn != nack_at);
      end else s_sda_low = 0;
    end else if (bc == 9) begin
      s_cont = (bn == 0) ? s_match : (mack_q.size() > 0 && mack_q[$] == 0);
      bc = 0; bn++;
      if (s_rd && s_cont) begin s_tx = rmem(bn-1); s_sda_low = !s_tx[7]; end
      else s_sda_low = 0;
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, v);
      if (!v[8]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cfgw(input int n, input bit rdm);
    return (32'(n - 1) << 1) | (32'(rdm) << 6);
  endfunction

  task automatic xfer(input logic [6:0] dev, input bit rdm, input int n, input bit wait_done);
    logic [31:0] v;
    wr(A_ADDR, {24'b0, dev, rdm});
    wr(A_CFG, cfgw(n, rdm));
    wr(A_LOAD, 32'd1);
    @(negedge clk);
    wr(A_CFG, cfgw(n, rdm) | 32'h200);
    rd(A_CFG, v);
    chk(v[9] == 1'b1, "R4", "go bit reads set while running", v[9], 1);
    if (wait_done) wait_idle();
  endtask

  task automatic push_write(input logic [31:0] lo, input logic [31:0] hi, input int n);
    for (int k = 0; k < n; k++)
      exp_q.push_back(k < 4 ? lo[8*k +: 8] : hi[8*(k-4) +: 8]);
  endtask

  logic [31:0] v, lo_e, hi_e;
  int xfers = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_STAT, v); chk(v == 0, "R1", "status after reset", v, 0);
    rd(A_CFG, v);  chk(v == 0, "R1", "config after reset", v, 0);
    rd(A_LOAD, v); chk(v == 0, "R1", "load after reset", v, 0);
    chk(!m_scl_low && !m_sda_low, "R1", "lines released", {m_scl_low, m_sda_low}, 0);

    // R2 shadow, R3 load timing
    wr(A_ADDR, {24'b0, TGT, 1'b0});
    rd(A_ADDR, v); chk(v == 0, "R2", "address before load", v, 0);
    wr(A_LOAD, 32'd1);
    rd(A_LOAD, v); chk(v == 1, "R3", "load bit right after write", v, 1);
    @(negedge clk);
    rd(A_LOAD, v); chk(v == 0, "R3", "load bit self-clears", v, 0);
    rd(A_ADDR, v); chk(v == {TGT, 1'b0}, "R2", "address after load", v, {TGT, 1'b0});

    // R5 R6 single byte write, R12 default divisor
    wr(A_LO, 32'h0000003C);
    push_write(32'h3C, 0, 1); got_cnt = 0;
    xfer(TGT, 0, 1, 1); xfers++;
    rd(A_STAT, v); chk(v == 0, "R11", "status after clean write", v, 0);
    rd(A_CFG, v);  chk(v[9] == 0, "R4", "go clears at end", v[9], 0);
    chk(got_cnt == 1, "R5", "bytes received", got_cnt, 1);
    chk(s_match && !s_rd, "R5", "address byte seen", {s_match, s_rd}, 2'b10);
    chk(last_period == 4, "R12", "scl period div 0", last_period, 4);

    // R6 eight bytes
    lo_e = 32'h44332211; hi_e = 32'h88776655;
    wr(A_LO, lo_e); wr(A_HI, hi_e);
    push_write(lo_e, hi_e, 8); got_cnt = 0;
    xfer(TGT, 0, 8, 1); xfers++;
    chk(got_cnt == 8 && exp_q.size() == 0, "R6", "eight byte write count", got_cnt, 8);

    // R6 five bytes
    lo_e = 32'hDEADBEEF; hi_e = 32'h000000C7;
    wr(A_LO, lo_e); wr(A_HI, hi_e);
    push_write(lo_e, hi_e, 5); got_cnt = 0;
    xfer(TGT, 0, 5, 1); xfers++;
    chk(got_cnt == 5, "R6", "five byte write count", got_cnt, 5);

    // R7 R8 eight byte read
    wr(A_LO, 0); wr(A_HI, 0); mack_q.delete();
    xfer(TGT, 1, 8, 1); xfers++;
    lo_e = {rmem(3), rmem(2), rmem(1), rmem(0)};
    hi_e = {rmem(7), rmem(6), rmem(5), rmem(4)};
    rd(A_LO, v); chk(v == lo_e, "R7", "read low word", v, lo_e);
    rd(A_HI, v); chk(v == hi_e, "R7", "read high word", v, hi_e);
    chk(mack_q.size() == 8, "R8", "master ack slots", mack_q.size(), 8);
    for (int k = 0; k < 8 && k < mack_q.size(); k++)
      chk(mack_q[k] == (k == 7), "R8", "master ack level", mack_q[k], (k == 7));

    // R7 three byte read keeps upper lanes
    wr(A_LO, 32'hFFFFFFFF); wr(A_HI, 32'h12345678); mack_q.delete();
    xfer(TGT, 1, 3, 1); xfers++;
    lo_e = {8'hFF, rmem(2), rmem(1), rmem(0)};
    rd(A_LO, v); chk(v == lo_e, "R7", "partial read low word", v, lo_e);
    rd(A_HI, v); chk(v == 32'h12345678, "R7", "untouched high word", v, 32'h12345678);
    chk(mack_q.size() == 3 && mack_q[2] == 1 && mack_q[0] == 0, "R8", "three byte acks",
        mack_q.size(), 3);

    // R9 address refused
    got_cnt = 0;
    xfer(7'h33, 0, 4, 1); xfers++;
    rd(A_STAT, v); chk(v[3:0] == 4'd1 && !v[8], "R9", "address nack status", v, 1);
    chk(got_cnt == 0, "R9", "no data clocked", got_cnt, 0);

    // R10 data refused on third byte; R11 nack flags renewed at go
    lo_e = 32'h0D0C0B0A; hi_e = 32'h00000F0E;
    wr(A_LO, lo_e); wr(A_HI, hi_e);
    push_write(lo_e, hi_e, 3); got_cnt = 0; nack_at = 3;
    xfer(TGT, 0, 6, 1); xfers++;
    nack_at = 0;
    rd(A_STAT, v); chk(v[3:0] == 4'd2, "R10", "data nack status", v, 2);
    chk(got_cnt == 3 && exp_q.size() == 0, "R10", "bytes before stop", got_cnt, 3);

    // R4 other-mode start bit is ignored
    v = start_cnt;
    wr(A_CFG, 32'h400);
    repeat (30) @(negedge clk);
    chk(start_cnt == v, "R4", "no start from bit 10", start_cnt, v);
    rd(A_STAT, v); chk(!v[8], "R4", "busy stays low", v[8], 0);

    // R12 divisor upper half drives timing
    wr(A_DIV, 32'h00030001);
    rd(A_DIV, v); chk(v == 0, "R2", "divisor before load", v, 0);
    wr(A_LOAD, 32'd1); @(negedge clk);
    rd(A_DIV, v); chk(v == 32'h00030001, "R12", "divisor read back", v, 32'h00030001);
    wr(A_LO, 32'h5A);
    push_write(32'h5A, 0, 1);
    xfer(TGT, 0, 1, 1); xfers++;
    chk(last_period == 16, "R12", "scl period div 3", last_period, 16);

    // R3 load during a transfer waits for idle
    lo_e = 32'h04030201; hi_e = 32'h08070605;
    wr(A_LO, lo_e); wr(A_HI, hi_e);
    push_write(lo_e, hi_e, 8);
    xfer(TGT, 0, 8, 0); xfers++;
    repeat (50) @(negedge clk);
    wr(A_ADDR, 32'h42); wr(A_LOAD, 32'd1);
    repeat (5) @(negedge clk);
    rd(A_LOAD, v); chk(v == 1, "R3", "load held while busy", v, 1);
    rd(A_ADDR, v); chk(v == {TGT, 1'b0}, "R3", "address frozen while busy", v, {TGT, 1'b0});
    wait_idle();
    @(negedge clk);
    rd(A_LOAD, v); chk(v == 0, "R3", "load done after idle", v, 0);
    rd(A_ADDR, v); chk(v == 32'h42, "R3", "address copied after idle", v, 32'h42);

    // R13 no stray start or stop from SDA moving with SCL high
    chk(start_cnt == xfers && stop_cnt == xfers, "R13", "start/stop count",
        start_cnt * 1000 + stop_cnt, xfers * 1000 + xfers);
    chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule